// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches thirteen general-purpose input pins and turns activity on them into interrupt requests. Every pin first passes through a two-flop synchronizer. The low eight pins each have a 3-bit trigger field, which selects one of five conditions: level high, level low, rising edge, falling edge, or either edge. The upper five pins always trigger on level high.

A detected condition sets a sticky pending bit. Software clears a pending bit by writing a one to it. When a new event and a clear land on the same bit in the same cycle, the event wins. A combined interrupt line is raised while any bit is pending.

For each of the low eight pins, a select bit chooses what drives that pin's dedicated coprocessor interrupt line: either the synchronized raw pin or the pin's pending bit. Software reaches the pending bits and the trigger/select word over a small register bus. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the pending bits, the trigger/select word, the coprocessor lines and the combined line are all zero.
- R2: A pin change reaches detection through two synchronizer flops. A pin changed just before clock edge A sets its pending bit at edge A+2.
- R3: Trigger code 000 (bits [3n+2:3n] for pin n) sets the bit while the synchronized pin is high. Pins 12..8 always use this level-high behaviour. A level source that is still active sets its bit again right after a clear.
- R4: Trigger code 001 sets the bit while the synchronized pin is low.
- R5: Code 010 sets the bit on a 0-to-1 change and code 011 on a 1-to-0 change. A pin that is held steady does not set the bit again after a clear.
- R6: Any code with bit 2 set (1xx) sets the bit on both rising and falling changes.
- R7: Writing to offset 0x0C clears each pending bit whose data bit is 1. Bits written with 0 keep their value.
- R8: If an event and a clear hit the same bit in the same cycle, the bit stays pending.
- R9: A read of offset 0x0C returns the pending bits in [12:0], with [31:13] reading zero. Writes to [31:13] have no effect. Any unmapped offset reads zero.
- R10: The trigger/select word at offset 0x10 is read/write. Bits [31:24] are the select bits for pins 7..0.
- R11: When a pin's select bit is 1, its coprocessor line follows the synchronized pin. When the select bit is 0, the line follows the pin's pending bit.
- R12: The combined interrupt output is the OR of all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 13 | Asynchronous general-purpose inputs |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| cop_irq | output | 8 | Per-pin coprocessor interrupt lines for pins 7..0 |
| irq_any | output | 1 | OR of all pending bits |

## Verification
The hardest case to reach is the collision between a freshly detected edge and a write-one-to-clear on the same bit. The event must appear exactly when the write takes effect. The bench first makes the bit pending through a rising-edge pin and returns the pin low. It then raises the pin on a falling clock edge, lets two rising edges pass through the synchronizer, and only then asserts the clear. That places the clear on the edge where the new event is captured, so the bit must read back as pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    // Trigger field encoding, bit 2 set means either edge
    localparam logic [1:0] TRIG_HIGH = 2'b00;
    localparam logic [1:0] TRIG_LOW  = 2'b01;
    localparam logic [1:0] TRIG_RISE = 2'b10;
    localparam logic [1:0] TRIG_FALL = 2'b11;
    localparam int         TRIG_W    = 3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pin_prev
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= '0;
        else        pin_prev <= chain[STAGES-1];
    end

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig,
    input  logic              cur,
    input  logic              prev,
    output logic              evt
);
    always_comb begin
        if (trig[2]) begin
            evt = cur ^ prev;
        end else begin
            unique case (trig[1:0])
                TRIG_HIGH: evt = cur;
                TRIG_LOW:  evt = ~cur;
                TRIG_RISE: evt = cur & ~prev;
                TRIG_FALL: evt = ~cur & prev;
                default:   evt = 1'b0;
            endcase
        end
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && (trig[2] || trig[1])) |-> (cur != prev)); // R5
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
    parameter int NUM_PINS   = 13,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int STATUS_OFS = 'h0C,
    parameter int TYPE_OFS   = 'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] evt,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pending,
    output logic [DATA_W-1:0]   type_word
);
    localparam int RES_W = DATA_W - NUM_PINS;

    logic hit_status, hit_type;
    logic [NUM_PINS-1:0] clr_mask;

    assign hit_status = (bus_addr == ADDR_W'(STATUS_OFS));
    assign hit_type   = (bus_addr == ADDR_W'(TYPE_OFS));
    assign clr_mask   = (bus_wr && hit_status) ? bus_wdata[NUM_PINS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  type_word <= '0;
        else if (bus_wr && hit_type) type_word <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (hit_status)    bus_rdata <= {{RES_W{1'b0}}, pending};
            else if (hit_type) bus_rdata <= type_word;
            else               bus_rdata <= '0;
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_status) |=> ((pending & $past(bus_wdata[NUM_PINS-1:0] & ~evt)) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pending & $past(evt)) == $past(evt))); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(evt)) == '0)); // R2
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_status) |=> (bus_rdata[DATA_W-1:NUM_PINS] == '0)); // R9
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 13,
    parameter int TYPED_PINS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [TYPED_PINS-1:0] cop_irq,
    output logic                  irq_any
);
    localparam int SEL_LSB = TRIG_W * TYPED_PINS;

    logic [NUM_PINS-1:0] pin_sync, pin_prev, evt, pending;
    logic [DATA_W-1:0]   type_word;

    gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .pin_sync(pin_sync), .pin_prev(pin_prev)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic [TRIG_W-1:0] trig;
            if (i < TYPED_PINS) begin : g_typed
                assign trig = type_word[TRIG_W*i +: TRIG_W];
            end else begin : g_fixed
                assign trig = {1'b0, TRIG_HIGH};
            end
            gpio_irq_detect u_det (
                .clk(clk), .rst_n(rst_n), .trig(trig),
                .cur(pin_sync[i]), .prev(pin_prev[i]), .evt(evt[i])
            );
        end
        for (genvar j = 0; j < TYPED_PINS; j++) begin : g_cop
            assign cop_irq[j] = type_word[SEL_LSB + j] ? pin_sync[j] : pending[j];
        end
    endgenerate

    gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .evt(evt),
        .bus_rdata(bus_rdata), .pending(pending), .type_word(type_word)
    );

    assign irq_any = |pending;

    AST_ANY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_any) |-> $past(|evt)); // R12
endmodule

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [12:0] pin_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cop_irq;
    logic        irq_any;

    int checks = 0, fails = 0;
    bit done = 0;

    localparam logic [7:0] ST = 8'h0C, TY = 8'h10;

    always #4 clk = ~clk;

    gpio_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cop_irq(cop_irq), .irq_any(irq_any)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] trig_at(input int pin, input logic [2:0] code);
        return 32'(code) << (3 * pin);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(ST, d); check(d == 0, "R1 status", d, 0);
        rd(TY, d); check(d == 0, "R1 type", d, 0);
        check({cop_irq, irq_any} == 0, "R1 outputs", {cop_irq, irq_any}, 0);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        pin_in[0] = 1;
        // R2: set at edge A+2; after two edges it must still be clear
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(irq_any == 0, "R2 latency early", irq_any, 0);
        @(negedge clk);
        check(irq_any == 1, "R2 latency set", irq_any, 1);
        wr(ST, 32'h1); rd(ST, d);
        check(d == 32'h1, "R3 level re-set", d, 1);
        pin_in[0] = 0; settle(); wr(ST, 32'h1); rd(ST, d);
        check(d == 0, "R7 cleared", d, 0);
        pin_in[12] = 1; settle(); rd(ST, d);
        check(d == 32'h1000, "R3 upper pin level", d, 32'h1000);
        pin_in[12] = 0; settle(); wr(ST, 32'h1FFF);
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        pin_in[1] = 1; settle();
        wr(TY, trig_at(1, 3'b001)); wr(ST, 32'h1FFF); rd(ST, d);
        check(d == 0, "R4 idle high", d, 0);
        pin_in[1] = 0; settle(); rd(ST, d);
        check(d == 32'h2, "R4 low sets", d, 2);
        wr(TY, 0); wr(ST, 32'h1FFF);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(TY, trig_at(2, 3'b010) | trig_at(3, 3'b011) | trig_at(4, 3'b100));
        pin_in[3] = 1; settle(); wr(ST, 32'h1FFF);
        pin_in[2] = 1; settle(); rd(ST, d);
        check(d == 32'h4, "R5 rising", d, 4);
        wr(ST, 32'h4); settle(); rd(ST, d);
        check(d == 0, "R5 no re-set held", d, 0);
        pin_in[2] = 0; pin_in[3] = 0; settle(); rd(ST, d);
        check(d == 32'h8, "R5 falling only", d, 8);
        wr(ST, 32'h1FFF);
        pin_in[4] = 1; settle(); rd(ST, d);
        check(d == 32'h10, "R6 both rise", d, 32'h10);
        wr(ST, 32'h10); pin_in[4] = 0; settle(); rd(ST, d);
        check(d == 32'h10, "R6 both fall", d, 32'h10);
        wr(ST, 32'h1FFF); wr(TY, 0);
    endtask

    task automatic t_w1c_and_reserved();
        logic [31:0] d;
        pin_in[5] = 1; pin_in[6] = 1;
        wr(TY, trig_at(5, 3'b010) | trig_at(6, 3'b010)); wr(ST, 32'h1FFF);
        pin_in[5] = 0; pin_in[6] = 0; settle();
        pin_in[5] = 1; pin_in[6] = 1; settle(); pin_in[5] = 0; pin_in[6] = 0; settle();
        wr(ST, 32'hFFFF_E000 | 32'h20); rd(ST, d);
        check(d == 32'h40, "R7 only ones clear", d, 32'h40);
        check(d[31:13] == 0, "R9 reserved zero", d, 32'h40);
        rd(8'h14, d); check(d == 0, "R9 unmapped", d, 0);
        irq_check: check(irq_any == 1, "R12 any", irq_any, 1);
        wr(ST, 32'h1FFF); wr(TY, 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(TY, trig_at(6, 3'b010));
        pin_in[6] = 1; settle(); pin_in[6] = 0; settle();
        rd(ST, d); check(d == 32'h40, "R8 pre pending", d, 32'h40);
        @(negedge clk); pin_in[6] = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = ST; bus_wdata = 32'h40; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        rd(ST, d); check(d == 32'h40, "R8 set wins", d, 32'h40);
        wr(ST, 32'h40); rd(ST, d);
        check(d == 0, "R7 clear after", d, 0);
        pin_in[6] = 0; settle(); wr(ST, 32'h1FFF); wr(TY, 0);
    endtask

    task automatic t_cop();
        logic [31:0] d;
        wr(TY, trig_at(5, 3'b010) | (32'h1 << 29));
        rd(TY, d); check(d == (trig_at(5, 3'b010) | (32'h1 << 29)), "R10 readback", d, 0);
        pin_in[5] = 1; settle();
        check(cop_irq[5] == 1, "R11 raw select", cop_irq, 8'h20);
        wr(ST, 32'h1FFF);
        check(cop_irq[5] == 1 && irq_any == 0, "R11 raw ignores status", {cop_irq, irq_any}, 32'h40);
        wr(TY, trig_at(5, 3'b010));
        check(cop_irq[5] == 0, "R11 status select", cop_irq, 0);
        pin_in[5] = 0; settle(); wr(TY, trig_at(5, 3'b011)); pin_in[5] = 0; settle();
        pin_in[5] = 1; settle(); pin_in[5] = 0; settle();
        check(cop_irq[5] == 1 && irq_any == 1, "R11 status drives", {cop_irq, irq_any}, 32'h41);
        wr(ST, 32'h1FFF);
        check(irq_any == 0, "R12 none pending", irq_any, 0);
        wr(TY, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_level_high();
        t_level_low();
        t_edges();
        t_w1c_and_reserved();
        t_collision();
        t_cop();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule